// File: doc/BRIEF.md
# Accumulator ALU with carry and zero flags

This block is the arithmetic stage of a small 8-bit processor. Each cycle it takes an operation code, a first operand and a second operand. The first operand is the accumulator or the index register. It returns a result together with a write enable that tells the register file whether to store that result. The block supports addition, subtraction, comparison, bitwise NOR, increment, decrement and a load pass-through.

The block also owns the two-bit status register, which holds a carry flag and a zero flag. Each operation updates only its own subset of the flags, and the block reports which flags it updates. The values the flags will take at the next clock edge appear on `c_next_o` and `z_next_o`. When an operation does not touch a flag, that flag's next value is its current value. Carry is produced only as a carry-out. The stored carry never feeds back into the arithmetic.

Top module: `acc_alu`

## Requirements
- R1: Code 1 (add) gives `res_o` = (a+b) mod 256 with `wr_o`=1. `c_next_o` is the carry-out of the 8-bit sum, both flag update enables are 1, and the current `c_o` has no influence on the result.
- R2: Code 2 (subtract) gives `res_o` = (a-b) mod 256 with `wr_o`=1. `c_next_o` is 1 exactly when a >= b (unsigned), so a borrow clears it. Both flags update.
- R3: Code 3 (compare, used for both the accumulator and the index register) gives the same `res_o`, `c_next_o` and `z_next_o` as code 2, with `wr_o`=0 and both flags updated.
- R4: Code 4 (NOR) gives `res_o` = ~(a|b) with `wr_o`=1. Only the zero flag updates, so `c_upd_o`=0 and `c_next_o`=`c_o`.
- R5: Codes 5 (increment) and 6 (decrement) give `res_o` = (a+1) mod 256 and (a-1) mod 256 with `wr_o`=1. Only the zero flag updates, and carry keeps its value.
- R6: Code 7 (load) gives `res_o` = b with `wr_o`=1. Only the zero flag updates.
- R7: Code 0 and codes 8 to 15 give `res_o`=0, `wr_o`=0 and both update enables 0. Both next-flag outputs equal the current flags.
- R8: Whenever `z_upd_o`=1, `z_next_o` is 1 exactly when `res_o` is zero. While `rst_n` is low, `c_o`=`z_o`=0. After each rising clock edge with `rst_n` high, `c_o` and `z_o` hold the values `c_next_o` and `z_next_o` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand (accumulator or index register) |
| b_i | input | W | Second operand |
| res_o | output | W | Operation result |
| wr_o | output | 1 | Result should be written to the destination register |
| c_next_o | output | 1 | Carry value after the next clock edge |
| z_next_o | output | 1 | Zero value after the next clock edge |
| c_upd_o | output | 1 | Operation updates the carry flag |
| z_upd_o | output | 1 | Operation updates the zero flag |
| c_o | output | 1 | Stored carry flag |
| z_o | output | 1 | Stored zero flag |

## Verification
The hardest situation to reach is a flag-preserving operation (NOR, increment, decrement, load) that runs while the stored carry is 1. The same applies to an addition that runs on top of a stored carry, because the carry state depends on earlier cycles. The stimulus clocks every vector through the flag register and orders the sweeps so that the flag state is left by the previous operation. Long add and subtract sweeps leave the carry flipping between 0 and 1, so later operations meet both states. A bench model tracks the expected flags across the whole run, and the stored flags are compared against it on every vector.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         c_next_o,
  output logic         z_next_o,
  output logic         c_upd_o,
  output logic         z_upd_o,
  output logic         c_o,
  output logic         z_o
);
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_CMP = 4'd3;
  localparam logic [3:0] OP_NOR = 4'd4;
  localparam logic [3:0] OP_INC = 4'd5;
  localparam logic [3:0] OP_DEC = 4'd6;
  localparam logic [3:0] OP_LD  = 4'd7;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W:0] sum, dif;
  logic       c_calc;

  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    res_o   = '0;
    wr_o    = 1'b0;
    c_upd_o = 1'b0;
    z_upd_o = 1'b0;
    c_calc  = 1'b0;
    case (op_i)
      OP_ADD: begin res_o = sum[W-1:0]; wr_o = 1'b1; c_upd_o = 1'b1; z_upd_o = 1'b1; c_calc = sum[W]; end
      OP_SUB: begin res_o = dif[W-1:0]; wr_o = 1'b1; c_upd_o = 1'b1; z_upd_o = 1'b1; c_calc = ~dif[W]; end
      OP_CMP: begin res_o = dif[W-1:0]; c_upd_o = 1'b1; z_upd_o = 1'b1; c_calc = ~dif[W]; end
      OP_NOR: begin res_o = ~(a_i | b_i); wr_o = 1'b1; z_upd_o = 1'b1; end
      OP_INC: begin res_o = a_i + ONE; wr_o = 1'b1; z_upd_o = 1'b1; end
      OP_DEC: begin res_o = a_i - ONE; wr_o = 1'b1; z_upd_o = 1'b1; end
      OP_LD:  begin res_o = b_i; wr_o = 1'b1; z_upd_o = 1'b1; end
      default: ;
    endcase
  end

  assign c_next_o = c_upd_o ? c_calc : c_o;
  assign z_next_o = z_upd_o ? (res_o == '0) : z_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_o <= 1'b0;
      z_o <= 1'b0;
    end else begin
      c_o <= c_next_o;
      z_o <= z_next_o;
    end
  end

  a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |-> (c_next_o == (res_o < a_i)));
  a_r2_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB || op_i == OP_CMP) |-> (c_next_o == (a_i >= b_i)));
  a_r3_cmp_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (!wr_o && c_upd_o && z_upd_o));
  a_r4_nor_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NOR) |=> (c_o == $past(c_o)));
  a_r5_incdec_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC || op_i == OP_DEC) |=> $stable(c_o));
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i[3]) |-> (!wr_o && !c_upd_o && !z_upd_o));
  a_r8_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({c_o, z_o} == $past({c_next_o, z_next_o})));
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'd0, b_i = 8'd0;
  logic [7:0] res_o;
  logic       wr_o, c_next_o, z_next_o, c_upd_o, z_upd_o, c_o, z_o;
  int total = 0, bad = 0;
  logic mc = 1'b0, mz = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu #(.W(8)) i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .wr_o(wr_o), .c_next_o(c_next_o), .z_next_o(z_next_o),
    .c_upd_o(c_upd_o), .z_upd_o(z_upd_o), .c_o(c_o), .z_o(z_o));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", tag, op_i, a_i, b_i, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5, 6: return "R5";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b);
    int r, w, cu, zu, cn, zn;
    @(negedge clk);
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
    #1;
    check("R8 stored carry", c_o, mc);
    check("R8 stored zero", z_o, mz);
    r = 0; w = 0; cu = 0; zu = 0; cn = mc; zn = mz;
    case (op)
      1: begin r = (a + b) % 256; w = 1; cu = 1; zu = 1; cn = (a + b > 255) ? 1 : 0; end
      2: begin r = (a - b + 256) % 256; w = 1; cu = 1; zu = 1; cn = (a >= b) ? 1 : 0; end
      3: begin r = (a - b + 256) % 256; cu = 1; zu = 1; cn = (a >= b) ? 1 : 0; end
      4: begin r = 255 - (a | b); w = 1; zu = 1; end
      5: begin r = (a + 1) % 256; w = 1; zu = 1; end
      6: begin r = (a + 255) % 256; w = 1; zu = 1; end
      7: begin r = b; w = 1; zu = 1; end
      default: ;
    endcase
    if (zu == 1) zn = (r == 0) ? 1 : 0;
    check({tag_of(op), " result"}, res_o, r);
    check({tag_of(op), " write"}, wr_o, w);
    check({tag_of(op), " c upd"}, c_upd_o, cu);
    check({tag_of(op), " z upd"}, z_upd_o, zu);
    check({tag_of(op), " c next"}, c_next_o, cn);
    check({tag_of(op), " R8 z next"}, z_next_o, zn);
    mc = cn[0]; mz = zn[0];
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    op_i = 4'd1; a_i = 8'd255; b_i = 8'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset carry", c_o, 0);
    check("R8 reset zero", z_o, 0);
    @(negedge clk);
    op_i = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int op = 0; op < 16; op++) begin
      int stp;
      stp = (op >= 1 && op <= 4) || op == 7 ? 5 : 85;
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += stp)
          apply(op, a, b);
    end
    apply(1, 200, 100);
    apply(4, 0, 0);
    apply(5, 255, 0);
    apply(6, 0, 0);
    apply(7, 0, 9);
    apply(1, 0, 0);
    apply(2, 1, 2);
    apply(4, 255, 0);
    apply(0, 0, 0);
    apply(3, 7, 7);
    apply(9, 1, 1);
    @(negedge clk);
    #1;
    check("R8 final carry", c_o, mc);
    check("R8 final zero", z_o, mz);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule